// File: doc/BRIEF.md
# Segment Access Rights Checker

This block decides whether a single memory access may proceed through a segment whose descriptor is already held in the CPU's segment cache. Each request carries the segment register index, the selector, a 32-bit offset, the kind of access and the current CPU mode, together with the cached descriptor attributes: the present bit, the low five access-rights bits, the granularity bit and the raw 20-bit limit. The block uses only these cached attributes. It does not load descriptors, check privilege levels or update the accessed bit.

The checks run in a fixed priority: presence first, then the null-selector test, then the type-versus-access test, then the limit test. The first check that fails sets the fault class (general protection or stack), a cause code and a flag that says whether an error code of zero is pushed. An access flagged as a prefetch still reports its fault status, but it does not raise the exception request. A request presented on any cycle gives its registered result one cycle later, marked by a done strobe.

Top module: `segchk_top`

## Requirements
- R1: A request with `req_valid` high gives its result on the outputs, with `done` high, in the cycle after it is accepted. `done` is low in any cycle that follows a cycle without a request. Reset clears `done`, `fault`, `exc_req`, `err_push`, `fault_class` and `fault_cause`.
- R2: The present bit is tested before any other check. When it is clear, the access faults with class 1 (general protection) and cause 2, whatever the mode, selector, type or offset.
- R3: Only in protected mode (`req_mode` = 1), an access through a segment other than CS (index 1) or SS (index 2) faults with class 1 and cause 1 when selector bits 15:2 are all zero. A selector with bit 2 set is not null. This check takes priority over the type and limit checks.
- R4: Type is `desc_ar[3:1]` (access-rights bits 3:1 read as an even value 0..14). Types 2 and 6 are writable data. In protected mode a write (`req_kind[3:0]` = 0) to types 0, 4, 8, 10, 12 or 14 faults with class 1 and cause 3.
- R5: In protected mode, execute-only code (types 8 and 12) accepts only opcode fetches (`req_kind[3:0]` = 3). A normal read (`req_kind[3:0]` = 1) or a write faults with class 1 and cause 3. Execute/read code (10, 14) allows reads and fetches.
- R6: In real mode (`req_mode` = 0) and virtual-8086 mode (`req_mode` = 2), the null-selector check and the type check are skipped. The present and limit checks still run.
- R7: The effective limit is the raw limit when `desc_gran` = 0. When `desc_gran` = 1 it is the raw limit shifted left by 12 with the low 12 bits set to ones.
- R8: An access is in range when offset <= effective limit. For expand-down data (`desc_ar[4:2]` = 3'b101) the result is inverted. An out-of-range access faults with cause 6.
- R9: A limit fault through SS (index 2) has class 2 (stack fault). A limit fault through any other segment has class 1.
- R10: `exc_req` equals `fault` except when prefetch flag `req_kind[4]` is set. In that case `fault`, `fault_class` and `fault_cause` are reported and `exc_req` stays low.
- R11: `err_push` is high for every fault in protected mode and low for every fault in real mode. In virtual-8086 mode it is low for a limit fault (cause 6) and high for any other fault. It is low when there is no fault.
- R12: The conforming bit (`desc_ar[2]` on code types) does not change the result: type 14 behaves as 10 and type 12 behaves as 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_seg | input | 3 | Segment index: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| req_sel | input | 16 | Selector held in the segment register |
| req_offset | input | 32 | Offset within the segment |
| req_kind | input | 5 | Bits 3:0: 0 write, 1 read, 3 opcode fetch; bit 4 prefetch flag |
| req_mode | input | 2 | 0 real, 1 protected, 2 virtual-8086 |
| desc_present | input | 1 | Cached present bit |
| desc_ar | input | 5 | Cached access-rights bits 4:0 |
| desc_gran | input | 1 | Cached granularity bit |
| desc_limit | input | 20 | Cached raw limit |
| done | output | 1 | Result valid strobe |
| fault | output | 1 | Access refused |
| fault_class | output | 2 | 0 none, 1 general protection, 2 stack fault |
| fault_cause | output | 3 | 0 none, 1 null selector, 2 not present, 3 type/access, 6 limit |
| exc_req | output | 1 | Exception to be raised (fault and not a prefetch) |
| err_push | output | 1 | Zero error code is pushed with the fault |

## Verification
The bench builds the block with its default parameters: a 32-bit offset, a 20-bit raw limit and a 12-bit granularity shift. With these values the byte-granular boundary at 0xFFF/0x1000, the page-granular boundary at 0x1FFF/0x2000 and the full 4 GiB segment (raw limit 0xFFFFF, offset 0xFFFFFFFF) can all be reached. The same boundaries are tried on an expand-down segment, so both sides of the inverted comparison are covered. The mode encodings let one descriptor be run through protected, real and virtual-8086 mode, which shows the checks being skipped and the error-code rule changing per mode.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  localparam int AR_W   = 5;
  localparam int KIND_W = 5;
  localparam int MODE_W = 2;
  localparam int CLS_W  = 2;
  localparam int CAU_W  = 3;

  localparam logic [MODE_W-1:0] MODE_REAL = 2'd0;
  localparam logic [MODE_W-1:0] MODE_PROT = 2'd1;
  localparam logic [MODE_W-1:0] MODE_V86  = 2'd2;

  localparam logic [CLS_W-1:0] FC_NONE = 2'd0;
  localparam logic [CLS_W-1:0] FC_GP   = 2'd1;
  localparam logic [CLS_W-1:0] FC_SS   = 2'd2;

  localparam logic [CAU_W-1:0] CAUSE_NONE   = 3'd0;
  localparam logic [CAU_W-1:0] CAUSE_NULL   = 3'd1;
  localparam logic [CAU_W-1:0] CAUSE_ABSENT = 3'd2;
  localparam logic [CAU_W-1:0] CAUSE_RIGHTS = 3'd3;
  localparam logic [CAU_W-1:0] CAUSE_LIMIT  = 3'd6;

  localparam logic [3:0] KIND_WRITE = 4'd0;
  localparam logic [3:0] KIND_READ  = 4'd1;
  localparam logic [3:0] KIND_FETCH = 4'd3;
  localparam int PREFETCH_BIT = 4;
endpackage

// File: rtl/segchk_limit.sv
module segchk_limit #(
  parameter int OFS_W      = 32,
  parameter int LIM_W      = 20,
  parameter int GRAN_SHIFT = 12
) (
  input  logic [LIM_W-1:0] raw_limit,
  input  logic             gran,
  input  logic [OFS_W-1:0] offset,
  input  logic             expand_down,
  output logic             in_range
);
  localparam int EFF_W = LIM_W + GRAN_SHIFT;
  localparam int CMP_W = (EFF_W > OFS_W) ? EFF_W : OFS_W;

  logic [CMP_W-1:0] lim_fine;
  logic [CMP_W-1:0] lim_coarse;
  logic [CMP_W-1:0] lim_eff;
  logic [CMP_W-1:0] ofs_ext;
  logic             below;

  generate
    if (GRAN_SHIFT > 0) begin : g_shift
      assign lim_coarse = CMP_W'({raw_limit, {GRAN_SHIFT{1'b1}}});
    end else begin : g_noshift
      assign lim_coarse = CMP_W'(raw_limit);
    end
  endgenerate

  assign lim_fine = CMP_W'(raw_limit);
  assign lim_eff  = gran ? lim_coarse : lim_fine;
  assign ofs_ext  = CMP_W'(offset);
  assign below    = (ofs_ext <= lim_eff);
  assign in_range = below ^ expand_down;
endmodule

// File: rtl/segchk_rights.sv
module segchk_rights
  import segchk_pkg::*;
#(
  parameter int SEL_W  = 16,
  parameter int SEG_W  = 3,
  parameter int CS_IDX = 1,
  parameter int SS_IDX = 2
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [SEG_W-1:0]  seg,
  input  logic [SEL_W-1:0]  sel,
  input  logic [2:0]        ar_type,
  input  logic [3:0]        kind,
  output logic              null_fault,
  output logic              rights_fault
);
  logic prot;
  logic stack_or_code;
  logic sel_null;
  logic is_code;
  logic can_write;
  logic exec_only;

  assign prot          = (mode == MODE_PROT);
  assign stack_or_code = (seg == SEG_W'(CS_IDX)) || (seg == SEG_W'(SS_IDX));
  assign sel_null      = (sel[SEL_W-1:2] == '0);
  assign null_fault    = prot && !stack_or_code && sel_null;

  // ar_type[2] = code, ar_type[0] = writable (data) / readable (code);
  // ar_type[1] (expand-down or conforming) plays no part in the rights.
  assign is_code   = ar_type[2];
  assign can_write = !is_code && ar_type[0];
  assign exec_only = is_code && !ar_type[0];

  always_comb begin
    rights_fault = 1'b0;
    if (prot) begin
      if (kind == KIND_WRITE)
        rights_fault = !can_write;
      else if (exec_only)
        rights_fault = (kind != KIND_FETCH);
    end
  end
endmodule

// File: rtl/segchk_top.sv
module segchk_top
  import segchk_pkg::*;
#(
  parameter int OFS_W      = 32,
  parameter int LIM_W      = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int SEL_W      = 16,
  parameter int SEG_W      = 3,
  parameter int CS_IDX     = 1,
  parameter int SS_IDX     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [4:0]       req_kind,
  input  logic [1:0]       req_mode,
  input  logic             desc_present,
  input  logic [4:0]       desc_ar,
  input  logic             desc_gran,
  input  logic [LIM_W-1:0] desc_limit,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_class,
  output logic [2:0]       fault_cause,
  output logic             exc_req,
  output logic             err_push
);
  logic             null_f;
  logic             rights_f;
  logic             in_range;
  logic             expand_down;
  logic             f_c;
  logic [CLS_W-1:0] cls_c;
  logic [CAU_W-1:0] cause_c;
  logic             err_c;
  logic             exc_c;

  assign expand_down = (desc_ar[4:2] == 3'b101);

  segchk_rights #(
    .SEL_W (SEL_W),
    .SEG_W (SEG_W),
    .CS_IDX(CS_IDX),
    .SS_IDX(SS_IDX)
  ) u_rights (
    .mode        (req_mode),
    .seg         (req_seg),
    .sel         (req_sel),
    .ar_type     (desc_ar[3:1]),
    .kind        (req_kind[3:0]),
    .null_fault  (null_f),
    .rights_fault(rights_f)
  );

  segchk_limit #(
    .OFS_W     (OFS_W),
    .LIM_W     (LIM_W),
    .GRAN_SHIFT(GRAN_SHIFT)
  ) u_limit (
    .raw_limit  (desc_limit),
    .gran       (desc_gran),
    .offset     (req_offset),
    .expand_down(expand_down),
    .in_range   (in_range)
  );

  // Fixed priority: present, null selector, type rights, limit.
  always_comb begin
    f_c     = 1'b1;
    cls_c   = FC_GP;
    cause_c = CAUSE_NONE;
    if (!desc_present)
      cause_c = CAUSE_ABSENT;
    else if (null_f)
      cause_c = CAUSE_NULL;
    else if (rights_f)
      cause_c = CAUSE_RIGHTS;
    else if (!in_range) begin
      cause_c = CAUSE_LIMIT;
      if (req_seg == SEG_W'(SS_IDX)) cls_c = FC_SS;
    end else begin
      f_c   = 1'b0;
      cls_c = FC_NONE;
    end
  end

  always_comb begin
    case (req_mode)
      MODE_PROT: err_c = f_c;
      MODE_V86:  err_c = f_c && (cause_c != CAUSE_LIMIT);
      default:   err_c = 1'b0;
    endcase
  end

  assign exc_c = f_c && !req_kind[PREFETCH_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_class <= FC_NONE;
      fault_cause <= CAUSE_NONE;
      exc_req     <= 1'b0;
      err_push    <= 1'b0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        fault       <= f_c;
        fault_class <= cls_c;
        fault_cause <= cause_c;
        exc_req     <= exc_c;
        err_push    <= err_c;
      end
    end
  end
endmodule

// File: rtl/segchk_sva.sv
module segchk_sva (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_seg,
  input logic [4:0] req_kind,
  input logic [1:0] req_mode,
  input logic       desc_present,
  input logic       done,
  input logic       fault,
  input logic [1:0] fault_class,
  input logic [2:0] fault_cause,
  input logic       exc_req,
  input logic       err_push
);
  assert_done_latency_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done);

  assert_absent_first_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !desc_present) |=> (fault && fault_cause == 3'd2 && fault_class == 2'd1));

  assert_realmode_no_rights_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode != 2'd1) |=> (fault_cause != 3'd1 && fault_cause != 3'd3));

  assert_stack_class_R9: assert property (@(posedge clk) disable iff (rst)
    (done && fault_class == 2'd2) |-> (fault && fault_cause == 3'd6));

  assert_prefetch_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind[4]) |=> !exc_req);

  assert_exc_needs_fault_R10: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> fault);

  assert_real_no_errcode_R11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd0) |=> !err_push);

  assert_pass_clean_R11: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (fault_class == 2'd0 && fault_cause == 3'd0 && !err_push));
endmodule

bind segchk_top segchk_sva u_sva (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_seg     (req_seg),
  .req_kind    (req_kind),
  .req_mode    (req_mode),
  .desc_present(desc_present),
  .done        (done),
  .fault       (fault),
  .fault_class (fault_class),
  .fault_cause (fault_cause),
  .exc_req     (exc_req),
  .err_push    (err_push)
);

// File: tb/tb_segchk_top.sv
`timescale 1ns/1ps
module tb_segchk_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_seg;
  logic [15:0] req_sel;
  logic [31:0] req_offset;
  logic [4:0]  req_kind;
  logic [1:0]  req_mode;
  logic        desc_present;
  logic [4:0]  desc_ar;
  logic        desc_gran;
  logic [19:0] desc_limit;
  logic        done;
  logic        fault;
  logic [1:0]  fault_class;
  logic [2:0]  fault_cause;
  logic        exc_req;
  logic        err_push;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  segchk_top #(
    .OFS_W(32), .LIM_W(20), .GRAN_SHIFT(12), .SEL_W(16), .SEG_W(3),
    .CS_IDX(1), .SS_IDX(2)
  ) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_seg(req_seg),
    .req_sel(req_sel), .req_offset(req_offset), .req_kind(req_kind),
    .req_mode(req_mode), .desc_present(desc_present), .desc_ar(desc_ar),
    .desc_gran(desc_gran), .desc_limit(desc_limit), .done(done),
    .fault(fault), .fault_class(fault_class), .fault_cause(fault_cause),
    .exc_req(exc_req), .err_push(err_push)
  );

  localparam logic [2:0] S_ES = 3'd0, S_CS = 3'd1, S_SS = 3'd2, S_DS = 3'd3;
  localparam logic [1:0] M_REAL = 2'd0, M_PROT = 2'd1, M_V86 = 2'd2;
  localparam logic [4:0] K_WR = 5'd0, K_RD = 5'd1, K_FE = 5'd3, K_PF = 5'h10;
  // access-rights bits 4:0, bit 4 = code/data descriptor, type in bits 3:1
  function automatic logic [4:0] ar(input int typ);
    return {1'b1, 4'(typ)};
  endfunction

  // expected packed: {done, fault, class[1:0], cause[2:0], exc, err}
  task automatic access(input string tag, input logic [1:0] mode,
                        input logic [2:0] seg, input logic [15:0] sel,
                        input logic [31:0] ofs, input logic [4:0] kind,
                        input logic pres, input logic [4:0] a,
                        input logic g, input logic [19:0] lim,
                        input logic f, input logic [1:0] cls,
                        input logic [2:0] cau, input logic exc,
                        input logic err);
    logic [8:0] exp_v, act_v;
    @(negedge clk);
    req_valid = 1'b1; req_mode = mode; req_seg = seg; req_sel = sel;
    req_offset = ofs; req_kind = kind; desc_present = pres; desc_ar = a;
    desc_gran = g; desc_limit = lim;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    exp_v = {1'b1, f, cls, cau, exc, err};
    act_v = {done, fault, fault_class, fault_cause, exc_req, err_push};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {done,fault,class,cause,exc,err} actual %b expected %b",
               tag, act_v, exp_v);
    end
  endtask

  task automatic t_reset_r1;
    rst = 1'b1; req_valid = 1'b0; req_seg = '0; req_sel = '0; req_offset = '0;
    req_kind = '0; req_mode = '0; desc_present = 1'b0; desc_ar = '0;
    desc_gran = 1'b0; desc_limit = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({done, fault, fault_class, fault_cause, exc_req, err_push} !== 9'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %b expected %b",
               {done, fault, fault_class, fault_cause, exc_req, err_push}, 9'b0);
    end
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_done_drop_r1;
    access("R1 pass access", M_PROT, S_DS, 16'h0010, 32'h10, K_RD, 1, ar(2), 0, 20'hFFF,
           0, 0, 0, 0, 0);
    @(posedge clk);
    #1;
    checks++;
    if (done !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle done: actual %b expected 0", done);
    end
  endtask

  task automatic t_present_r2;
    access("R2 absent prot null write", M_PROT, S_DS, 16'h0000, 32'hFFFF_0000, K_WR, 0, ar(0), 0, 20'h0,
           1, 1, 2, 1, 1);
    access("R2 absent real", M_REAL, S_SS, 16'h0000, 32'h0, K_RD, 0, ar(2), 0, 20'hFFFF,
           1, 1, 2, 1, 0);
  endtask

  task automatic t_null_r3;
    access("R3 DS null beats rights", M_PROT, S_DS, 16'h0003, 32'h0, K_WR, 1, ar(0), 0, 20'hFFF,
           1, 1, 1, 1, 1);
    access("R3 ES null", M_PROT, S_ES, 16'h0000, 32'h0, K_RD, 1, ar(2), 0, 20'hFFF,
           1, 1, 1, 1, 1);
    access("R3 LDT bit not null", M_PROT, S_DS, 16'h0004, 32'h0, K_RD, 1, ar(2), 0, 20'hFFF,
           0, 0, 0, 0, 0);
    access("R3 CS exempt", M_PROT, S_CS, 16'h0000, 32'h0, K_FE, 1, ar(10), 0, 20'hFFF,
           0, 0, 0, 0, 0);
    access("R3 SS exempt", M_PROT, S_SS, 16'h0000, 32'h0, K_WR, 1, ar(2), 0, 20'hFFF,
           0, 0, 0, 0, 0);
  endtask

  task automatic t_write_r4;
    access("R4 write RO data", M_PROT, S_DS, 16'h08, 32'h0, K_WR, 1, ar(0), 0, 20'hFFF,
           1, 1, 3, 1, 1);
    access("R4 write RO expdown", M_PROT, S_DS, 16'h08, 32'h2000, K_WR, 1, ar(4), 0, 20'hFFF,
           1, 1, 3, 1, 1);
    access("R4 write XR code", M_PROT, S_DS, 16'h08, 32'h0, K_WR, 1, ar(10), 0, 20'hFFF,
           1, 1, 3, 1, 1);
    access("R4 write RW data", M_PROT, S_DS, 16'h08, 32'h0, K_WR, 1, ar(2), 0, 20'hFFF,
           0, 0, 0, 0, 0);
    access("R4 rights before limit", M_PROT, S_SS, 16'h08, 32'h5000, K_WR, 1, ar(0), 0, 20'hFFF,
           1, 1, 3, 1, 1);
  endtask

  task automatic t_execonly_r5;
    access("R5 read X code", M_PROT, S_CS, 16'h08, 32'h0, K_RD, 1, ar(8), 0, 20'hFFF,
           1, 1, 3, 1, 1);
    access("R5 fetch X code", M_PROT, S_CS, 16'h08, 32'h0, K_FE, 1, ar(8), 0, 20'hFFF,
           0, 0, 0, 0, 0);
    access("R5 read XR code", M_PROT, S_DS, 16'h08, 32'h0, K_RD, 1, ar(10), 0, 20'hFFF,
           0, 0, 0, 0, 0);
  endtask

  task automatic t_modes_r6;
    access("R6 real write RO", M_REAL, S_DS, 16'h0000, 32'h0, K_WR, 1, ar(0), 0, 20'hFFFF,
           0, 0, 0, 0, 0);
    access("R6 v86 read X code null", M_V86, S_ES, 16'h0000, 32'h0, K_RD, 1, ar(8), 0, 20'hFFFF,
           0, 0, 0, 0, 0);
    access("R6 real limit still runs", M_REAL, S_DS, 16'h0000, 32'h10000, K_RD, 1, ar(2), 0, 20'hFFFF,
           1, 1, 6, 1, 0);
  endtask

  task automatic t_limit_r7_r8;
    access("R7 byte gran at limit", M_PROT, S_DS, 16'h08, 32'h0FFF, K_RD, 1, ar(2), 0, 20'h00FFF,
           0, 0, 0, 0, 0);
    access("R7 byte gran past limit", M_PROT, S_DS, 16'h08, 32'h1000, K_RD, 1, ar(2), 0, 20'h00FFF,
           1, 1, 6, 1, 1);
    access("R7 page gran top", M_PROT, S_DS, 16'h08, 32'h1FFF, K_RD, 1, ar(2), 1, 20'h00001,
           0, 0, 0, 0, 0);
    access("R7 page gran past", M_PROT, S_DS, 16'h08, 32'h2000, K_RD, 1, ar(2), 1, 20'h00001,
           1, 1, 6, 1, 1);
    access("R7 full 4G", M_PROT, S_DS, 16'h08, 32'hFFFF_FFFF, K_WR, 1, ar(2), 1, 20'hFFFFF,
           0, 0, 0, 0, 0);
    access("R8 expdown at limit", M_PROT, S_DS, 16'h08, 32'h0FFF, K_RD, 1, ar(6), 0, 20'h00FFF,
           1, 1, 6, 1, 1);
    access("R8 expdown above", M_PROT, S_DS, 16'h08, 32'h1000, K_WR, 1, ar(6), 0, 20'h00FFF,
           0, 0, 0, 0, 0);
    access("R8 expdown code bit clear not inverted", M_PROT, S_DS, 16'h08, 32'h1000, K_RD, 1, 5'b00110, 0, 20'h00FFF,
           1, 1, 6, 1, 1);
  endtask

  task automatic t_stack_r9;
    access("R9 SS limit", M_PROT, S_SS, 16'h10, 32'h2000, K_WR, 1, ar(2), 0, 20'h00FFF,
           1, 2, 6, 1, 1);
    access("R9 SS expdown limit", M_PROT, S_SS, 16'h10, 32'h0800, K_RD, 1, ar(6), 0, 20'h00FFF,
           1, 2, 6, 1, 1);
    access("R9 CS limit is GP", M_PROT, S_CS, 16'h08, 32'h2000, K_FE, 1, ar(10), 0, 20'h00FFF,
           1, 1, 6, 1, 1);
  endtask

  task automatic t_prefetch_r10;
    access("R10 prefetch limit", M_PROT, S_CS, 16'h08, 32'h2000, K_FE | K_PF, 1, ar(10), 0, 20'h00FFF,
           1, 1, 6, 0, 1);
    access("R10 prefetch absent", M_REAL, S_CS, 16'h0, 32'h0, K_FE | K_PF, 0, ar(10), 0, 20'hFFFF,
           1, 1, 2, 0, 0);
  endtask

  task automatic t_errcode_r11;
    access("R11 v86 limit no err", M_V86, S_DS, 16'h0, 32'h10000, K_RD, 1, ar(2), 0, 20'hFFFF,
           1, 1, 6, 1, 0);
    access("R11 v86 SS limit no err", M_V86, S_SS, 16'h0, 32'h10000, K_RD, 1, ar(2), 0, 20'hFFFF,
           1, 2, 6, 1, 0);
    access("R11 v86 absent err", M_V86, S_DS, 16'h0, 32'h0, K_RD, 0, ar(2), 0, 20'hFFFF,
           1, 1, 2, 1, 1);
    access("R11 real limit no err", M_REAL, S_SS, 16'h0, 32'h10000, K_RD, 1, ar(2), 0, 20'hFFFF,
           1, 2, 6, 1, 0);
  endtask

  task automatic t_conforming_r12;
    access("R12 conf XR write", M_PROT, S_DS, 16'h08, 32'h0, K_WR, 1, ar(14), 0, 20'hFFF,
           1, 1, 3, 1, 1);
    access("R12 conf XR read", M_PROT, S_DS, 16'h08, 32'h0, K_RD, 1, ar(14), 0, 20'hFFF,
           0, 0, 0, 0, 0);
    access("R12 conf X read", M_PROT, S_CS, 16'h08, 32'h0, K_RD, 1, ar(12), 0, 20'hFFF,
           1, 1, 3, 1, 1);
    access("R12 conf X fetch", M_PROT, S_CS, 16'h08, 32'hFFF, K_FE, 1, ar(12), 0, 20'hFFF,
           0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset_r1();
    t_done_drop_r1();
    t_present_r2();
    t_null_r3();
    t_write_r4();
    t_execonly_r5();
    t_modes_r6();
    t_limit_r7_r8();
    t_stack_r9();
    t_prefetch_r10();
    t_errcode_r11();
    t_conforming_r12();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule